// File: doc/BRIEF.md
# I2S Transmit Serializer

This block turns a stream of stereo sample pairs into one serial audio data line. A separate clock generator supplies a word-select level together with one-cycle pulses that mark the rising and falling edges of the bit clock. The serializer shifts one data bit per selected bit-clock edge and places each channel's sample inside its half of the frame. The placement follows a latched format: a one-bit delay after the word-select change (standard I2S), left-justified, or right-justified. It also honours a word length of 16, 24 or 32 bits inside a channel slot that may be longer than the sample.

A sample source presents a left/right pair with a valid flag. The serializer takes the pair at the first bit of each left-channel half and pulses a ready strobe in that cycle. If no pair is offered, it sends an all-zero frame and reports an underflow pulse. The configuration inputs are captured only while the transmitter is disabled, so a running stream never changes format mid-frame.

Top module: `i2s_tx_serializer`

## Requirements
- R1: The word-length code selects the sample width: 0 gives 16 bits, 1 gives 24 bits, and 2 or 3 give 32 bits. The sample occupies the low bits of the 32-bit input word, and bits above the width are ignored.
- R2: With delay and right-justify both clear (left-justified), the sample MSB goes out on the first shift tick of its channel half, the tick on which word-select is seen to change.
- R3: With delay set and right-justify clear (I2S), the MSB goes out one bit after the word-select change. When the sample fills the whole slot, its LSB goes out on the first bit of the following half.
- R4: With right-justify set, the sample LSB goes out on the last bit of the slot (slot index SLOT_BITS-1) and the delay bit has no effect.
- R5: Every slot bit that carries no sample bit, including bits beyond the slot when word-select stays longer, is sent as 0.
- R6: When cfg_ws_left_high is 0, a low word-select marks the left channel; when it is 1, a high word-select marks the left channel.
- R7: When cfg_shift_rise is 1, data shifts on bclk_rise_en pulses; when it is 0, data shifts on bclk_fall_en pulses. Pulses of the other edge change nothing. sd_out takes each new bit one clock after the shift tick.
- R8: Sample bits are sent MSB first.
- R9: A pair is loaded only on the shift tick that starts a left half, with smp_ready high in that same cycle. Changes to the sample inputs during a frame do not affect that frame.
- R10: If smp_valid is low at a frame start, the frame is sent as all zeros and underflow is high for exactly the one clock after that tick.
- R11: Configuration inputs are captured only while tx_en is low. Changes made while tx_en is high do not affect the stream.
- R12: While tx_en is low, sd_out is 0 from the next clock on. After enabling, the first shift tick only records word-select, and output stays 0 until the first left half begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable; configuration is captured while low |
| cfg_wlen | input | 2 | Word-length code (0:16, 1:24, 2/3:32 bits) |
| cfg_delay | input | 1 | One-bit MSB delay after word-select change |
| cfg_rjust | input | 1 | Right-justify the sample in its slot |
| cfg_ws_left_high | input | 1 | Word-select level that marks the left channel |
| cfg_shift_rise | input | 1 | 1: shift on rising bit-clock edge, 0: on falling |
| bclk_rise_en | input | 1 | One-cycle pulse at each bit-clock rising edge |
| bclk_fall_en | input | 1 | One-cycle pulse at each bit-clock falling edge |
| ws_in | input | 1 | Word-select level from the clock generator |
| smp_valid | input | 1 | A stereo pair is offered |
| smp_left | input | 32 | Left sample, right-aligned |
| smp_right | input | 32 | Right sample, right-aligned |
| smp_ready | output | 1 | Pair taken in this cycle |
| sd_out | output | 1 | Serial data |
| underflow | output | 1 | One-clock pulse after a frame start with no pair |

## Verification
The assertions take for granted that the clock generator changes word-select only together with a shift-edge pulse, and that rising and falling pulses never coincide. The bench drives every bit as a non-shift pulse cycle followed by a shift pulse cycle, with word-select updated only in the shift cycle. Each channel half lasts exactly SLOT_BITS shift ticks. The bench changes configuration only while the transmitter is disabled, except in the one test that checks such changes are ignored.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;

    localparam int MAX_SAMPLE_W = 32;

    typedef struct packed {
        logic [1:0] wlen;
        logic       delay;
        logic       rjust;
        logic       ws_left_high;
        logic       shift_rise;
    } tx_cfg_t;

    function automatic int wlen_to_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 16;
            2'd1:    return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/i2stx_cfg_hold.sv
module i2stx_cfg_hold
    import i2stx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tx_en,
    input  tx_cfg_t cfg_in,
    output tx_cfg_t cfg_q
);
    tx_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (!tx_en) cfg_d = cfg_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end
endmodule

// File: rtl/i2stx_tick_sel.sv
module i2stx_tick_sel (
    input  logic shift_rise,
    input  logic rise_en,
    input  logic fall_en,
    output logic tick
);
    always_comb begin
        tick = shift_rise ? rise_en : fall_en;
    end
endmodule

// File: rtl/i2stx_slot_map.sv
module i2stx_slot_map
    import i2stx_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int CNT_W     = $clog2(SLOT_BITS + 1)
) (
    input  tx_cfg_t                 cfg,
    input  logic [CNT_W-1:0]        slot_idx,
    input  logic [MAX_SAMPLE_W-1:0] cur,
    input  logic [MAX_SAMPLE_W-1:0] prev,
    output logic                    bit_o
);
    localparam int IW = $clog2(MAX_SAMPLE_W);

    int         width;
    int         first;
    int         pos;
    int         rel;
    logic [IW-1:0] sel;

    always_comb begin
        width = wlen_to_bits(cfg.wlen);
        first = cfg.rjust ? (SLOT_BITS - width) : (cfg.delay ? 1 : 0);
        pos   = int'(slot_idx);
        rel   = pos - first;
        sel   = '0;
        bit_o = 1'b0;
        if (pos < SLOT_BITS) begin
            if (pos >= first) begin
                if (rel < width) begin
                    sel   = IW'(width - 1 - rel);
                    bit_o = cur[sel];
                end
            end else if (cfg.delay && !cfg.rjust && (width >= SLOT_BITS)) begin
                bit_o = prev[0];
            end
        end
    end
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
    import i2stx_pkg::*;
#(
    parameter int SLOT_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_en,
    input  logic [1:0]  cfg_wlen,
    input  logic        cfg_delay,
    input  logic        cfg_rjust,
    input  logic        cfg_ws_left_high,
    input  logic        cfg_shift_rise,
    input  logic        bclk_rise_en,
    input  logic        bclk_fall_en,
    input  logic        ws_in,
    input  logic        smp_valid,
    input  logic [31:0] smp_left,
    input  logic [31:0] smp_right,
    output logic        smp_ready,
    output logic        sd_out,
    output logic        underflow
);
    localparam int CNT_W = $clog2(SLOT_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SLOT_BITS);

    typedef struct packed {
        logic                    primed;
        logic                    active;
        logic                    ws_prev;
        logic                    chan_right;
        logic [CNT_W-1:0]        cnt;
        logic [MAX_SAMPLE_W-1:0] left;
        logic [MAX_SAMPLE_W-1:0] right;
        logic                    sd;
        logic                    uflow;
    } state_t;

    state_t  s_q, s_d;
    tx_cfg_t cfg_in, cfg_q;
    logic    shift_tick;
    logic    ws_change, is_left, load_now, map_bit;
    logic [CNT_W-1:0]        slot_idx;
    logic [MAX_SAMPLE_W-1:0] load_left, load_right, cur_smp, prev_smp;

    assign cfg_in = '{wlen: cfg_wlen, delay: cfg_delay, rjust: cfg_rjust,
                      ws_left_high: cfg_ws_left_high, shift_rise: cfg_shift_rise};

    i2stx_cfg_hold u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_en  (tx_en),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    i2stx_tick_sel u_tick (
        .shift_rise (cfg_q.shift_rise),
        .rise_en    (bclk_rise_en),
        .fall_en    (bclk_fall_en),
        .tick       (shift_tick)
    );

    // Channel and slot position decoding for the current shift tick.
    always_comb begin
        ws_change  = s_q.primed && (ws_in != s_q.ws_prev);
        is_left    = (ws_in == cfg_q.ws_left_high);
        load_now   = tx_en && shift_tick && ws_change && is_left;
        load_left  = smp_valid ? smp_left  : '0;
        load_right = smp_valid ? smp_right : '0;
        slot_idx   = ws_change ? '0 : s_q.cnt;
        if (load_now) begin
            cur_smp  = load_left;
            prev_smp = s_q.right;
        end else if (ws_change ? !is_left : s_q.chan_right) begin
            cur_smp  = s_q.right;
            prev_smp = s_q.left;
        end else begin
            cur_smp  = s_q.left;
            prev_smp = s_q.right;
        end
    end

    i2stx_slot_map #(.SLOT_BITS(SLOT_BITS), .CNT_W(CNT_W)) u_map (
        .cfg      (cfg_q),
        .slot_idx (slot_idx),
        .cur      (cur_smp),
        .prev     (prev_smp),
        .bit_o    (map_bit)
    );

    always_comb begin
        s_d       = s_q;
        s_d.uflow = 1'b0;
        if (!tx_en) begin
            s_d = '0;
        end else if (shift_tick) begin
            s_d.ws_prev = ws_in;
            if (!s_q.primed) begin
                s_d.primed = 1'b1;
            end else begin
                if (ws_change) begin
                    s_d.chan_right = !is_left;
                    s_d.cnt        = CNT_W'(1);
                end else if (s_q.cnt != CNT_END) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
                if (load_now) begin
                    s_d.active = 1'b1;
                    s_d.left   = load_left;
                    s_d.right  = load_right;
                    s_d.uflow  = !smp_valid;
                end
                s_d.sd = (s_q.active || load_now) ? map_bit : 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign smp_ready = load_now;
    assign sd_out    = s_q.sd;
    assign underflow = s_q.uflow;
endmodule

// File: rtl/i2s_tx_serializer_chk.sv
module i2s_tx_serializer_chk
    import i2stx_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    tx_en,
    input logic    shift_tick,
    input logic    smp_valid,
    input logic    smp_ready,
    input logic    sd_out,
    input logic    underflow,
    input tx_cfg_t cfg_q
);
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!sd_out && !underflow));

    p_sd_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_out) |-> ($past(shift_tick) || !$past(tx_en)));

    p_ready_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> (tx_en && shift_tick));

    p_uflow_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> $past(smp_ready && !smp_valid));

    p_uflow_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> !underflow);

    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en)) |-> $stable(cfg_q));
endmodule

bind i2s_tx_serializer i2s_tx_serializer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .shift_tick (shift_tick),
    .smp_valid  (smp_valid),
    .smp_ready  (smp_ready),
    .sd_out     (sd_out),
    .underflow  (underflow),
    .cfg_q      (cfg_q)
);

// File: tb/tb_i2s_tx_serializer.sv
`timescale 1ns/1ps
module tb_i2s_tx_serializer;
    localparam int SLOT = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic [1:0]  cfg_wlen = '0;
    logic        cfg_delay = 1'b0, cfg_rjust = 1'b0;
    logic        cfg_ws_left_high = 1'b0, cfg_shift_rise = 1'b0;
    logic        bclk_rise_en = 1'b0, bclk_fall_en = 1'b0, ws_in = 1'b1;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_left = '0, smp_right = '0;
    logic        smp_ready, sd_out, underflow;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    logic [1:0] e_wlen;
    logic       e_dly, e_rj, e_wsp, e_rise;

    typedef struct packed {
        logic [1:0]  wlen;
        logic        dly;
        logic        rj;
        logic        wsp;
        logic        rise;
        logic [31:0] l;
        logic [31:0] r;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_A5C3, 32'h0000_3C5A},
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00AB_CDEF, 32'h0012_3456},
        '{2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 32'h8000_0001, 32'hC000_0003},
        '{2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_1234, 32'h0000_8001},
        '{2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 32'hDEAD_BEEF, 32'h0F0F_00F1},
        '{2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0055_AA01, 32'hFF80_0001}
    };

    i2s_tx_serializer #(.SLOT_BITS(SLOT)) dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
        .cfg_wlen(cfg_wlen), .cfg_delay(cfg_delay), .cfg_rjust(cfg_rjust),
        .cfg_ws_left_high(cfg_ws_left_high), .cfg_shift_rise(cfg_shift_rise),
        .bclk_rise_en(bclk_rise_en), .bclk_fall_en(bclk_fall_en), .ws_in(ws_in),
        .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
        .smp_ready(smp_ready), .sd_out(sd_out), .underflow(underflow)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bits_of(input logic [1:0] code);
        return (code == 2'd0) ? 16 : (code == 2'd1) ? 24 : 32;
    endfunction

    // Frame image: sample starts at st; a delayed full-slot sample spills
    // its tail into the start of the next half.
    function automatic logic ref_bit(input int k, input logic [31:0] s, input logic [31:0] ps);
        int w, st, j;
        w  = bits_of(e_wlen);
        st = e_rj ? SLOT - w : (e_dly ? 1 : 0);
        if (k >= st && k < st + w) return s[w - 1 - (k - st)];
        j = k + SLOT - st;
        if (j >= 0 && j < w) return ps[w - 1 - j];
        return 1'b0;
    endfunction

    task automatic shift_bit(input logic ws, output logic rdy);
        @(negedge clk);
        if (e_rise) bclk_fall_en = 1'b1; else bclk_rise_en = 1'b1;
        @(negedge clk);
        bclk_rise_en = 1'b0; bclk_fall_en = 1'b0;
        if (e_rise) bclk_rise_en = 1'b1; else bclk_fall_en = 1'b1;
        ws_in = ws;
        #1 rdy = smp_ready;
        @(negedge clk);
        bclk_rise_en = 1'b0; bclk_fall_en = 1'b0;
    endtask

    task automatic run_frame(input logic [31:0] l, input logic [31:0] r,
                             input logic [31:0] pr, input logic exp_uf,
                             input int chg_at, input logic [31:0] new_l);
        logic rdy;
        for (int h = 0; h < 2; h++) begin
            for (int k = 0; k < SLOT; k++) begin
                shift_bit(h == 0 ? e_wsp : !e_wsp, rdy);
                chk(32'(sd_out), 32'(ref_bit(k, h == 0 ? l : r, h == 0 ? pr : l)),
                    "R2 R3 R4 R5 R6 R8 R1 serial bit");
                if (h == 0 && k == 0) begin
                    chk(32'(rdy), 32'd1, "R9 ready at frame start");
                    chk(32'(underflow), 32'(exp_uf), "R10 underflow flag");
                end
                if (h == 0 && k == 1) chk(32'(underflow), 32'd0, "R10 underflow one clock");
                if (h == 1 && k == 0) chk(32'(rdy), 32'd0, "R9 no load on right half");
                if (h == 0 && k == chg_at) smp_left = new_l;
            end
        end
    endtask

    task automatic setup(input vec_t v);
        logic rdy;
        @(negedge clk);
        tx_en = 1'b0;
        cfg_wlen = v.wlen; cfg_delay = v.dly; cfg_rjust = v.rj;
        cfg_ws_left_high = v.wsp; cfg_shift_rise = v.rise;
        e_wlen = v.wlen; e_dly = v.dly; e_rj = v.rj; e_wsp = v.wsp; e_rise = v.rise;
        repeat (2) @(negedge clk);
        tx_en = 1'b1;
        shift_bit(!v.wsp, rdy);
        chk(32'(sd_out), 32'd0, "R12 priming tick sends zero");
    endtask

    initial begin
        logic rdy;
        logic hold;
        vec_t v;
        e_wlen = '0; e_dly = 0; e_rj = 0; e_wsp = 0; e_rise = 0;
        repeat (3) @(negedge clk);
        chk(32'(sd_out), 32'd0, "R12 reset sd_out");
        chk(32'(underflow), 32'd0, "R10 reset underflow");
        chk(32'(smp_ready), 32'd0, "R9 reset ready");
        rst_n = 1'b1;

        // Table walk over formats, widths and polarities.
        foreach (VECS[i]) begin
            v = VECS[i];
            smp_valid = 1'b1; smp_left = v.l; smp_right = v.r;
            setup(v);
            run_frame(v.l, v.r, 32'h0, 1'b0, -1, 32'h0);
            run_frame(v.l, v.r, v.r, 1'b0, -1, 32'h0);
            run_frame(v.l, v.r, v.r, 1'b0, -1, 32'h0);
        end

        // R10: no pair offered gives a zero frame and an underflow pulse.
        smp_valid = 1'b0; smp_left = 32'hFFFF_FFFF; smp_right = 32'hFFFF_FFFF;
        setup(VECS[0]);
        run_frame(32'h0, 32'h0, 32'h0, 1'b1, -1, 32'h0);

        // R9: sample change mid-frame only shows in the next frame.
        v = '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'hF0F0_1234, 32'h0000_00FF};
        smp_valid = 1'b1; smp_left = v.l; smp_right = v.r;
        setup(v);
        run_frame(v.l, v.r, 32'h0, 1'b0, 4, 32'h0F0F_8765);
        run_frame(32'h0F0F_8765, v.r, v.r, 1'b0, -1, 32'h0);

        // R11: configuration changed while enabled is ignored.
        v = '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_C001, 32'h0000_7FFE};
        smp_left = v.l; smp_right = v.r;
        setup(v);
        cfg_wlen = 2'd2; cfg_rjust = 1'b1; cfg_delay = 1'b1;
        cfg_ws_left_high = 1'b1; cfg_shift_rise = 1'b1;
        run_frame(v.l, v.r, 32'h0, 1'b0, -1, 32'h0);

        // R7: a pulse on the non-shift edge with word-select moved is ignored.
        @(negedge clk);
        hold = sd_out;
        bclk_rise_en = 1'b1; ws_in = e_wsp;
        #1 chk(32'(smp_ready), 32'd0, "R7 other edge does not load");
        @(negedge clk);
        bclk_rise_en = 1'b0;
        chk(32'(sd_out), 32'(hold), "R7 other edge keeps sd_out");
        ws_in = !e_wsp;

        // R12: disable drives zero one clock later.
        setup(v);
        shift_bit(e_wsp, rdy);
        chk(32'(sd_out), 32'd1, "R8 MSB of C001 first");
        @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(32'(sd_out), 32'd0, "R12 disable clears sd_out");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule